// File: doc/BRIEF.md
# Thread-Block Resource Admission Unit

This unit sits beside a compute core's block dispatcher and decides whether one more thread block fits on the core. Every candidate block is described by three numbers: its thread count, the registers each thread needs, and the bytes of shared memory the whole block needs. The unit keeps a running total of threads, registers, shared memory and resident blocks. It also keeps a bitmap with one bit for each hardware thread slot. Because the decision depends only on what is currently resident, blocks from different kernels can live on the core at the same time.

The answer is combinational. From the request inputs and the current state, the unit presents an accept bit and the first slot of the thread range it would hand out, all in the same cycle. A dispatcher can read that answer without touching any state. To reserve the block, it raises the commit strobe in a cycle where the answer is accept. Separate inputs hand back a finished block's budget and free individual thread slots as their threads exit.

Top module: `blk_admit`

## Requirements
- R1: A block's thread count is rounded up to the next multiple of `WARP` (default 8). The rounded count is the one charged to the thread budget and used for register cost; 5 requested threads occupy 8.
- R2: A request is rejected when resident threads plus the rounded count would exceed `MAX_THREADS` (default 64). Reaching exactly `MAX_THREADS` is allowed.
- R3: Candidate start slots are 0, P, 2P, … where P is the rounded count; a candidate qualifies only if slots [start, start+P) are all inside the core and all free. The lowest qualifying start is reported on `q_start`, and the request is rejected when no candidate qualifies.
- R4: Register cost is P times the per-thread register count rounded up to a multiple of 4. A request is rejected when resident registers plus this cost would exceed `REG_CAP` (default 1024).
- R5: A request is rejected when resident shared memory plus its byte count would exceed `SMEM_CAP` (default 4096). It is also rejected when `MAX_BLOCKS` (default 4) blocks are already resident.
- R6: Presenting a request without `commit_en` changes no state. A commit of an accepted request adds P threads, the register cost, the shared-memory bytes and one block to the totals at the next clock edge.
- R7: A commit sets bitmap bits from `q_start` for the block's actual (unrounded) thread count. `exit_en` clears the single bit `exit_slot` at the next edge.
- R8: `rel_en` subtracts exactly the amounts a commit of the same thread/register/shared-memory triple would have charged, plus one block. If any total would drop below zero, nothing is subtracted and `rel_err` is set and stays set until reset.
- R9: Synchronous active-high `rst` clears all four totals, the whole bitmap and `rel_err`.
- R10: A request for zero threads is never accepted. `commit_en` asserted while `q_accept` is low changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high full-core reset |
| req_threads | input | TW (7) | Thread count of the candidate block |
| req_regs | input | RW (8) | Registers per thread of the candidate block |
| req_smem | input | SW (13) | Shared-memory bytes of the candidate block |
| commit_en | input | 1 | Reserve the candidate block if accepted |
| q_accept | output | 1 | Candidate fits (combinational) |
| q_start | output | IW (6) | First thread slot of the range the candidate would receive |
| rel_en | input | 1 | Return a finished block's budget |
| rel_threads | input | TW (7) | Thread count of the finished block |
| rel_regs | input | RW (8) | Registers per thread of the finished block |
| rel_smem | input | SW (13) | Shared-memory bytes of the finished block |
| exit_en | input | 1 | One thread has exited |
| exit_slot | input | IW (6) | Slot index of the exiting thread |
| used_threads | output | TCW (7) | Resident rounded thread total |
| used_regs | output | RCW (11) | Resident register total |
| used_smem | output | SCW (13) | Resident shared-memory total |
| used_blocks | output | BCW (3) | Resident block count |
| slot_map | output | MAX_THREADS (64) | Active thread-slot bitmap |
| rel_err | output | 1 | Sticky release-underflow flag |

## Verification
Each budget is driven to exactly its limit and then one unit past it, with the other three budgets left loose, so a rejection can be traced to a single cause. Placement is tried with block sizes that are not multiples of the warp, with windows that are busy only in their low slots, and with a fragmented bitmap whose totals still have room. These cases separate the aligned first-fit search from a plain count check, and they also show that the unrounded count is what marks the bitmap. Releases are tried once with matching amounts and once with no matching resident block, which shows the exact refund apart from the underflow guard.

// File: rtl/adm_pkg.sv
package adm_pkg;

    typedef logic [31:0] amt_t;

    typedef struct packed {
        amt_t threads;
        amt_t regs;
        amt_t smem;
    } cost_t;

    localparam int NUM_BUDGETS = 4;
    localparam int B_THR  = 0;
    localparam int B_REG  = 1;
    localparam int B_SMEM = 2;
    localparam int B_BLK  = 3;

    // Round n up to a multiple of m (m > 0).
    function automatic amt_t round_up(amt_t n, amt_t m);
        return ((n + m - 1) / m) * m;
    endfunction

    // Per-thread register count rounded up to a multiple of four.
    function automatic amt_t reg_round(amt_t r);
        return (r + 32'd3) & ~32'd3;
    endfunction

endpackage

// File: rtl/adm_sizer.sv
module adm_sizer
    import adm_pkg::*;
#(
    parameter int WARP = 8,
    parameter int TW   = 7,
    parameter int RW   = 8,
    parameter int SW   = 13
) (
    input  logic [TW-1:0] threads,
    input  logic [RW-1:0] regs,
    input  logic [SW-1:0] smem,
    output cost_t         cost
);
    amt_t padded;

    always_comb begin
        padded       = round_up(amt_t'(threads), amt_t'(WARP));
        cost.threads = padded;
        cost.regs    = padded * reg_round(amt_t'(regs));
        cost.smem    = amt_t'(smem);
    end
endmodule

// File: rtl/adm_counter.sv
module adm_counter
    import adm_pkg::*;
#(
    parameter int CAP = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic add_en,
    input  amt_t add_amt,
    input  logic sub_en,
    input  amt_t sub_amt,
    output amt_t value,
    output logic fits,
    output logic short_o
);
    localparam int VW = $clog2(CAP + 1);

    logic [VW-1:0] cnt_q;

    assign value   = amt_t'(cnt_q);
    assign fits    = (value + add_amt) <= amt_t'(CAP);
    assign short_o = value < sub_amt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (add_en || sub_en)
            cnt_q <= VW'(value + (add_en ? add_amt : '0) - (sub_en ? sub_amt : '0));
    end
endmodule

// File: rtl/adm_slot_map.sv
module adm_slot_map
    import adm_pkg::*;
#(
    parameter int N    = 64,
    parameter int WARP = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  amt_t                 need,
    input  logic                 set_en,
    input  amt_t                 set_len,
    input  logic                 clr_en,
    input  logic [$clog2(N)-1:0] clr_idx,
    output logic                 found,
    output logic [$clog2(N)-1:0] start,
    output logic [N-1:0]         map
);
    localparam int NW = N / WARP;
    localparam int IW = $clog2(N);

    logic [N-1:0]  map_q;
    logic [NW-1:0] hit;
    amt_t          start_a;
    logic [N-1:0]  set_mask;
    logic [N-1:0]  clr_mask;

    function automatic logic [N-1:0] ones(amt_t len);
        if (len == 0)
            return '0;
        else if (len >= amt_t'(N))
            return '1;
        else
            return {N{1'b1}} >> (amt_t'(N) - len);
    endfunction

    // One candidate window per multiple of the rounded size.
    for (genvar k = 0; k < NW; k++) begin : g_win
        amt_t win_lo;
        assign win_lo = amt_t'(k) * need;
        assign hit[k] = (need != 0) &&
                        ((win_lo + need) <= amt_t'(N)) &&
                        ((map_q & (ones(need) << win_lo)) == '0);
    end

    // Lowest qualifying window wins.
    always_comb begin
        found   = 1'b0;
        start_a = '0;
        for (int k = NW - 1; k >= 0; k--) begin
            if (hit[k]) begin
                found   = 1'b1;
                start_a = amt_t'(k) * need;
            end
        end
    end

    assign start    = start_a[IW-1:0];
    assign set_mask = set_en ? (ones(set_len) << start_a) : '0;
    assign clr_mask = clr_en ? (N'(1) << clr_idx) : '0;
    assign map      = map_q;

    always_ff @(posedge clk) begin
        if (rst)
            map_q <= '0;
        else
            map_q <= (map_q & ~clr_mask) | set_mask;
    end
endmodule

// File: rtl/blk_admit.sv
module blk_admit
    import adm_pkg::*;
#(
    parameter int MAX_THREADS = 64,
    parameter int WARP        = 8,
    parameter int REG_CAP     = 1024,
    parameter int SMEM_CAP    = 4096,
    parameter int MAX_BLOCKS  = 4,
    parameter int RW          = 8,
    localparam int TW  = $clog2(MAX_THREADS + 1),
    localparam int SW  = $clog2(SMEM_CAP + 1),
    localparam int IW  = $clog2(MAX_THREADS),
    localparam int TCW = $clog2(MAX_THREADS + 1),
    localparam int RCW = $clog2(REG_CAP + 1),
    localparam int SCW = $clog2(SMEM_CAP + 1),
    localparam int BCW = $clog2(MAX_BLOCKS + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [TW-1:0]          req_threads,
    input  logic [RW-1:0]          req_regs,
    input  logic [SW-1:0]          req_smem,
    input  logic                   commit_en,
    output logic                   q_accept,
    output logic [IW-1:0]          q_start,
    input  logic                   rel_en,
    input  logic [TW-1:0]          rel_threads,
    input  logic [RW-1:0]          rel_regs,
    input  logic [SW-1:0]          rel_smem,
    input  logic                   exit_en,
    input  logic [IW-1:0]          exit_slot,
    output logic [TCW-1:0]         used_threads,
    output logic [RCW-1:0]         used_regs,
    output logic [SCW-1:0]         used_smem,
    output logic [BCW-1:0]         used_blocks,
    output logic [MAX_THREADS-1:0] slot_map,
    output logic                   rel_err
);
    cost_t rq_cost;
    cost_t rl_cost;
    amt_t  add_amt [NUM_BUDGETS];
    amt_t  sub_amt [NUM_BUDGETS];
    amt_t  val     [NUM_BUDGETS];
    logic [NUM_BUDGETS-1:0] fits;
    logic [NUM_BUDGETS-1:0] shorts;
    logic  win_found;
    logic  do_commit;
    logic  do_rel;
    logic  rel_bad;
    logic  err_q;

    adm_sizer #(.WARP(WARP), .TW(TW), .RW(RW), .SW(SW)) u_rq_size (
        .threads (req_threads),
        .regs    (req_regs),
        .smem    (req_smem),
        .cost    (rq_cost)
    );

    adm_sizer #(.WARP(WARP), .TW(TW), .RW(RW), .SW(SW)) u_rl_size (
        .threads (rel_threads),
        .regs    (rel_regs),
        .smem    (rel_smem),
        .cost    (rl_cost)
    );

    always_comb begin
        add_amt[B_THR]  = rq_cost.threads;
        add_amt[B_REG]  = rq_cost.regs;
        add_amt[B_SMEM] = rq_cost.smem;
        add_amt[B_BLK]  = 32'd1;
        sub_amt[B_THR]  = rl_cost.threads;
        sub_amt[B_REG]  = rl_cost.regs;
        sub_amt[B_SMEM] = rl_cost.smem;
        sub_amt[B_BLK]  = 32'd1;
    end

    assign q_accept  = (rq_cost.threads != 0) && (&fits) && win_found;
    assign do_commit = commit_en && q_accept;
    assign rel_bad   = rel_en && (|shorts);
    assign do_rel    = rel_en && !(|shorts);

    for (genvar g = 0; g < NUM_BUDGETS; g++) begin : g_budget
        localparam int CAP_G = (g == B_THR)  ? MAX_THREADS :
                               (g == B_REG)  ? REG_CAP     :
                               (g == B_SMEM) ? SMEM_CAP    : MAX_BLOCKS;
        adm_counter #(.CAP(CAP_G)) u_cnt (
            .clk     (clk),
            .rst     (rst),
            .add_en  (do_commit),
            .add_amt (add_amt[g]),
            .sub_en  (do_rel),
            .sub_amt (sub_amt[g]),
            .value   (val[g]),
            .fits    (fits[g]),
            .short_o (shorts[g])
        );
    end

    adm_slot_map #(.N(MAX_THREADS), .WARP(WARP)) u_slots (
        .clk     (clk),
        .rst     (rst),
        .need    (rq_cost.threads),
        .set_en  (do_commit),
        .set_len (amt_t'(req_threads)),
        .clr_en  (exit_en),
        .clr_idx (exit_slot),
        .found   (win_found),
        .start   (q_start),
        .map     (slot_map)
    );

    always_ff @(posedge clk) begin
        if (rst)
            err_q <= 1'b0;
        else if (rel_bad)
            err_q <= 1'b1;
    end

    assign rel_err      = err_q;
    assign used_threads = val[B_THR][TCW-1:0];
    assign used_regs    = val[B_REG][RCW-1:0];
    assign used_smem    = val[B_SMEM][SCW-1:0];
    assign used_blocks  = val[B_BLK][BCW-1:0];
endmodule

// File: rtl/blk_admit_chk.sv
module blk_admit_chk #(
    parameter int MAX_THREADS = 64,
    parameter int WARP        = 8,
    parameter int REG_CAP     = 1024,
    parameter int SMEM_CAP    = 4096,
    parameter int MAX_BLOCKS  = 4,
    parameter int IW  = 6,
    parameter int TCW = 7,
    parameter int RCW = 11,
    parameter int SCW = 13,
    parameter int BCW = 3
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   commit_en,
    input logic                   rel_en,
    input logic                   exit_en,
    input logic                   q_accept,
    input logic [IW-1:0]          q_start,
    input logic [TCW-1:0]         used_threads,
    input logic [RCW-1:0]         used_regs,
    input logic [SCW-1:0]         used_smem,
    input logic [BCW-1:0]         used_blocks,
    input logic [MAX_THREADS-1:0] slot_map,
    input logic                   rel_err
);
    // R2
    a_r2_thread_cap: assert property (@(posedge clk) disable iff (rst)
        int'(used_threads) <= MAX_THREADS);

    // R3
    a_r3_start_aligned: assert property (@(posedge clk) disable iff (rst)
        q_accept |-> (int'(q_start) % WARP) == 0);

    // R4
    a_r4_reg_cap: assert property (@(posedge clk) disable iff (rst)
        int'(used_regs) <= REG_CAP);

    // R5
    a_r5_smem_cap: assert property (@(posedge clk) disable iff (rst)
        int'(used_smem) <= SMEM_CAP);

    // R5
    a_r5_block_cap: assert property (@(posedge clk) disable iff (rst)
        int'(used_blocks) <= MAX_BLOCKS);

    // R6
    a_r6_query_keeps_state: assert property (@(posedge clk) disable iff (rst)
        (!commit_en && !rel_en && !exit_en) |=>
        ($stable(used_threads) && $stable(used_regs) && $stable(used_smem) &&
         $stable(used_blocks) && $stable(slot_map)));

    // R6
    a_r6_commit_adds_block: assert property (@(posedge clk) disable iff (rst)
        (commit_en && q_accept && !rel_en) |=>
        used_blocks == $past(used_blocks) + 1'b1);

    // R7
    a_r7_start_slot_marked: assert property (@(posedge clk) disable iff (rst)
        (commit_en && q_accept && !exit_en) |=> slot_map[$past(q_start)]);

    // R8
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
        rel_err |=> rel_err);

    // R9
    a_r9_reset_clears: assert property (@(posedge clk)
        rst |=> (used_threads == '0 && used_regs == '0 && used_smem == '0 &&
                 used_blocks == '0 && slot_map == '0 && !rel_err));

    // R10
    a_r10_reject_no_effect: assert property (@(posedge clk) disable iff (rst)
        (commit_en && !q_accept && !rel_en && !exit_en) |=>
        ($stable(used_blocks) && $stable(used_threads) && $stable(slot_map)));
endmodule

bind blk_admit blk_admit_chk #(
    .MAX_THREADS (MAX_THREADS),
    .WARP        (WARP),
    .REG_CAP     (REG_CAP),
    .SMEM_CAP    (SMEM_CAP),
    .MAX_BLOCKS  (MAX_BLOCKS),
    .IW          (IW),
    .TCW         (TCW),
    .RCW         (RCW),
    .SCW         (SCW),
    .BCW         (BCW)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .commit_en    (commit_en),
    .rel_en       (rel_en),
    .exit_en      (exit_en),
    .q_accept     (q_accept),
    .q_start      (q_start),
    .used_threads (used_threads),
    .used_regs    (used_regs),
    .used_smem    (used_smem),
    .used_blocks  (used_blocks),
    .slot_map     (slot_map),
    .rel_err      (rel_err)
);

// File: tb/blk_admit_test.sv
`timescale 1ns/1ps
module blk_admit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  req_threads = '0;
    logic [7:0]  req_regs = '0;
    logic [12:0] req_smem = '0;
    logic        commit_en = 1'b0;
    logic        q_accept;
    logic [5:0]  q_start;
    logic        rel_en = 1'b0;
    logic [6:0]  rel_threads = '0;
    logic [7:0]  rel_regs = '0;
    logic [12:0] rel_smem = '0;
    logic        exit_en = 1'b0;
    logic [5:0]  exit_slot = '0;
    logic [6:0]  used_threads;
    logic [10:0] used_regs;
    logic [12:0] used_smem;
    logic [2:0]  used_blocks;
    logic [63:0] slot_map;
    logic        rel_err;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    blk_admit uut (
        .clk(clk), .rst(rst),
        .req_threads(req_threads), .req_regs(req_regs), .req_smem(req_smem),
        .commit_en(commit_en), .q_accept(q_accept), .q_start(q_start),
        .rel_en(rel_en), .rel_threads(rel_threads), .rel_regs(rel_regs), .rel_smem(rel_smem),
        .exit_en(exit_en), .exit_slot(exit_slot),
        .used_threads(used_threads), .used_regs(used_regs), .used_smem(used_smem),
        .used_blocks(used_blocks), .slot_map(slot_map), .rel_err(rel_err)
    );

    task automatic chk(string tag, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; commit_en = 1'b0; rel_en = 1'b0; exit_en = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        #1;
    endtask

    task automatic ask(int t, int r, int s);
        req_threads = 7'(t); req_regs = 8'(r); req_smem = 13'(s);
        #1;
    endtask

    task automatic commit_blk(int t, int r, int s);
        ask(t, r, s);
        commit_en = 1'b1;
        @(negedge clk);
        commit_en = 1'b0;
        #1;
    endtask

    task automatic release_blk(int t, int r, int s);
        rel_threads = 7'(t); rel_regs = 8'(r); rel_smem = 13'(s);
        rel_en = 1'b1;
        @(negedge clk);
        rel_en = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R9 threads after reset", used_threads, 0);
        chk("R9 map after reset", slot_map, 0);
        commit_blk(5, 3, 100);
        release_blk(40, 0, 0);
        chk("R8 err before reset", rel_err, 1);
        do_reset();
        chk("R9 threads cleared", used_threads, 0);
        chk("R9 regs cleared", used_regs, 0);
        chk("R9 smem cleared", used_smem, 0);
        chk("R9 blocks cleared", used_blocks, 0);
        chk("R9 map cleared", slot_map, 0);
        chk("R9 err cleared", rel_err, 0);
    endtask

    task automatic t_pad_commit();
        do_reset();
        ask(5, 3, 100);
        chk("R1 accept 5 threads", q_accept, 1);
        chk("R3 start 0", q_start, 0);
        @(negedge clk); #1;
        chk("R6 query leaves threads", used_threads, 0);
        chk("R6 query leaves map", slot_map, 0);
        commit_blk(5, 3, 100);
        chk("R1 padded threads", used_threads, 8);
        chk("R4 regs 8*4", used_regs, 32);
        chk("R6 smem charged", used_smem, 100);
        chk("R6 block counted", used_blocks, 1);
        chk("R7 map actual count", slot_map, 64'h1F);
    endtask

    task automatic t_window();
        do_reset();
        commit_blk(5, 0, 0);
        ask(16, 4, 0);
        chk("R3 16-block skips busy window", q_start, 16);
        commit_blk(16, 4, 0);
        chk("R7 map 16..31", slot_map, 64'hFFFF_001F);
        chk("R4 regs 16*4", used_regs, 64);
        ask(8, 0, 0);
        chk("R3 8-block at 8", q_start, 8);
        chk("R3 8-block accepted", q_accept, 1);
        // fragmentation
        do_reset();
        commit_blk(32, 0, 0);
        ask(8, 0, 0);
        chk("R3 after 32 block start", q_start, 32);
        commit_blk(8, 0, 0);
        release_blk(32, 0, 0);
        chk("R8 threads after release", used_threads, 8);
        ask(32, 0, 0);
        chk("R3 no free aligned window", q_accept, 0);
        ask(8, 0, 0);
        chk("R3 small block at 40", q_start, 40);
        chk("R3 small block accepted", q_accept, 1);
    endtask

    task automatic t_threads();
        do_reset();
        commit_blk(56, 0, 0);
        ask(9, 0, 0);
        chk("R2 9 rounds to 16 over cap", q_accept, 0);
        ask(8, 0, 0);
        chk("R2 exactly at cap", q_accept, 1);
        chk("R3 last window", q_start, 56);
    endtask

    task automatic t_regs();
        do_reset();
        ask(8, 125, 0);
        chk("R4 cost equals cap accepted", q_accept, 1);
        commit_blk(8, 125, 0);
        chk("R4 regs 8*128", used_regs, 1024);
        ask(8, 1, 0);
        chk("R4 one more over cap", q_accept, 0);
        ask(8, 0, 0);
        chk("R4 zero regs fits", q_accept, 1);
    endtask

    task automatic t_smem_blocks();
        do_reset();
        commit_blk(8, 0, 4000);
        ask(8, 0, 97);
        chk("R5 smem over cap", q_accept, 0);
        ask(8, 0, 96);
        chk("R5 smem at cap", q_accept, 1);
        do_reset();
        for (int i = 0; i < 4; i++) commit_blk(8, 0, 0);
        chk("R5 four blocks resident", used_blocks, 4);
        ask(8, 0, 0);
        chk("R5 fifth block rejected", q_accept, 0);
    endtask

    task automatic t_no_effect();
        do_reset();
        commit_blk(64, 0, 0);
        ask(8, 0, 0);
        chk("R10 full core rejects", q_accept, 0);
        commit_blk(8, 0, 0);
        chk("R10 rejected commit threads", used_threads, 64);
        chk("R10 rejected commit blocks", used_blocks, 1);
        do_reset();
        ask(0, 0, 0);
        chk("R10 zero threads rejected", q_accept, 0);
        commit_blk(0, 0, 0);
        chk("R10 zero commit no block", used_blocks, 0);
    endtask

    task automatic t_release_exit();
        do_reset();
        commit_blk(5, 3, 100);
        exit_slot = 6'd2; exit_en = 1'b1;
        @(negedge clk); exit_en = 1'b0; #1;
        chk("R7 exit clears slot 2", slot_map, 64'h1B);
        release_blk(5, 3, 100);
        chk("R8 threads refunded", used_threads, 0);
        chk("R8 regs refunded", used_regs, 0);
        chk("R8 smem refunded", used_smem, 0);
        chk("R8 blocks refunded", used_blocks, 0);
        chk("R8 no err", rel_err, 0);
        release_blk(5, 3, 100);
        chk("R8 underflow flagged", rel_err, 1);
        chk("R8 underflow keeps blocks", used_blocks, 0);
        commit_blk(8, 0, 0);
        chk("R8 err sticky", rel_err, 1);
    endtask

    initial begin
        #(200000 * 8);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        t_reset();
        t_pad_commit();
        t_window();
        t_threads();
        t_regs();
        t_smem_blocks();
        t_no_effect();
        t_release_exit();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule